// File: doc/BRIEF.md
# Prioritised Video Source Change-Over Controller

This block decides which of three video sources drives the downstream processing path. The sources are the optical input, the electrical input and an internal pattern generator. Configuration supplies a ranked list of one to three sources. The controller starts at the top of that list. It steps down when the selected source fails and steps back up when a better-ranked source has recovered. Status decoding, the generator and the video multiplexer sit outside the block. The block takes per-input fault flags and a millisecond tick, and it delivers a source code for the mux and a status code.

Three timing guards shape the switching. A hold timer keeps a failing source on air for a set number of milliseconds, so that short dropouts do not cause a switch. A lock timer makes a recovered source prove itself for a set number of milliseconds before the controller returns to it. An optional latch freezes the controller on a lower-ranked physical source after a failover. The latch applies only when the trigger rule is loss of signal, and a clear strobe releases it. The generator is always treated as a last resort: the controller leaves it for a recovered physical input even while latched.

Top module: `prio_changeover`

## Requirements
- R1: Source codes are 0 = optical, 1 = electrical, 2 = generator, and 3 = an entry that is always failing. List entry k sits in `cfg_prio[2k+1:2k]`, and entry 0 ranks highest. After reset `sel_src` equals entry 0.
- R2: When `cfg_manual` is 1, the controller behaves as if the list held only entry 0 and never leaves it, even while that source fails.
- R3: `cfg_rule` selects the fault flag that counts as failure: 0 = loss of signal, 1 = loss of lock, 2 = timing reference error, 3 = any of them. The other flags have no effect.
- R4: A failing selected source stays selected until it has failed through `cfg_hold_ms` tick pulses. The controller then moves to the highest-ranked lower entry that is not failing. With a hold of 0, the move happens on the next clock.
- R5: The controller returns to a higher-ranked entry only after that source has been non-failing through `cfg_lock_ms` tick pulses.
- R6: Any fault cycle, even one without a tick, restarts the lock count of that source. Any good cycle of the selected source restarts its hold count.
- R7: With `cfg_latch` = 1 and rule 0, a failover sets a latched state. While that state is set and the selected source is physical, the controller never returns upward.
- R8: Under rules 1 to 3 the latch has no effect, and failback behaves as in R5.
- R9: While the generator is selected, the controller returns to a recovered higher-ranked physical entry even when latched.
- R10: A one-cycle pulse on `latch_clr` clears the latched state, so failback per R5 resumes.
- R11: When several higher-ranked sources complete their lock time on the same tick, the highest-ranked one is chosen.
- R12: `status` is 3 while the selected source is failing. Otherwise it is 2 while latched away from entry 0, 0 on entry 0, and 1 on any other entry.
- R13: Only entries below `cfg_len` are used. A value of 0 counts as 1. When no usable lower entry is healthy, the failing source stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_manual | input | 1 | Manual mode (single entry) |
| cfg_len | input | 2 | Number of list entries used |
| cfg_prio | input | 6 | Priority list, 2 bits per entry, entry 0 in the low bits |
| cfg_rule | input | 2 | Trigger rule select |
| cfg_latch | input | 1 | Latch enable |
| cfg_hold_ms | input | 16 | Hold time in ticks |
| cfg_lock_ms | input | 16 | Lock time in ticks |
| latch_clr | input | 1 | Latch clear strobe |
| in_los | input | 2 | Loss of signal, bit 0 optical, bit 1 electrical |
| in_lol | input | 2 | Loss of lock per physical input |
| in_trs | input | 2 | Timing reference error per physical input |
| sel_src | output | 2 | Selected source code |
| status | output | 2 | Controller status code |

## Verification
A table of flag patterns drives the main path through a sequence that exercises each distinct behaviour:
- a single primary failure, stopped one tick short of the hold time and then one tick after it;
- a recovery stopped one tick short of the lock time;
- a double failure that lands on the generator;
- a simultaneous recovery that separates the rank order from arrival order;
- backup-only faults and faults on an unselected rule, which must leave the output untouched.

Directed runs then cover:
- each rule in isolation;
- glitches that must restart both timers;
- the latch under the loss-of-signal rule and under another rule, its clear strobe, and the exit from the generator;
- a shortened list and a zero hold time.

// File: rtl/cho_pkg.sv
package cho_pkg;
   localparam int NPHYS = 2;
   localparam logic [1:0] SRC_OPT  = 2'd0;
   localparam logic [1:0] SRC_ELEC = 2'd1;
   localparam logic [1:0] SRC_GEN  = 2'd2;
   localparam logic [1:0] SRC_NONE = 2'd3;

   localparam logic [1:0] RULE_LOS = 2'd0;
   localparam logic [1:0] RULE_LOL = 2'd1;
   localparam logic [1:0] RULE_TRS = 2'd2;

   typedef enum logic [1:0] {
      ST_PRIMARY = 2'd0,
      ST_BACKUP  = 2'd1,
      ST_LATCHED = 2'd2,
      ST_HOLDING = 2'd3
   } cho_status_e;
endpackage

// File: rtl/cho_health.sv
module cho_health
   import cho_pkg::*;
#(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic [1:0]       rule,
   input  logic             los,
   input  logic             lol,
   input  logic             trs,
   input  logic [TMR_W-1:0] lock_ms,
   output logic             bad,
   output logic             settled
);
   logic [TMR_W-1:0] good_cnt_q;

   always_comb begin
      case (rule)
         RULE_LOS: bad = los;
         RULE_LOL: bad = lol;
         RULE_TRS: bad = trs;
         default:  bad = los | lol | trs;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n || bad)
         good_cnt_q <= '0;
      else if (ms_tick && good_cnt_q != '1)
         good_cnt_q <= good_cnt_q + 1'b1;
   end

   assign settled = !bad && (good_cnt_q >= lock_ms);

   // R6
   settle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> (good_cnt_q == '0));
endmodule

// File: rtl/cho_hold_timer.sv
module cho_hold_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic             cur_bad,
   input  logic             restart,
   input  logic [TMR_W-1:0] hold_ms,
   output logic             expired
);
   logic [TMR_W-1:0] hold_cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart || !cur_bad)
         hold_cnt_q <= '0;
      else if (ms_tick && hold_cnt_q != '1)
         hold_cnt_q <= hold_cnt_q + 1'b1;
   end

   assign expired = cur_bad && (hold_cnt_q >= hold_ms);

   // R6
   hold_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_cnt_q != '0) |=> (hold_cnt_q == '0) || (hold_cnt_q >= $past(hold_cnt_q)));
endmodule

// File: rtl/cho_select.sv
module cho_select
   import cho_pkg::*;
#(
   parameter int LEVELS = 3,
   parameter int LEN_W  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_manual,
   input  logic [LEN_W-1:0]    cfg_len,
   input  logic [2*LEVELS-1:0] cfg_prio,
   input  logic                cfg_latch,
   input  logic                latch_rule,
   input  logic                latch_clr,
   input  logic [3:0]          src_bad,
   input  logic [3:0]          src_settled,
   input  logic                hold_expired,
   output logic [1:0]          sel_src,
   output logic [1:0]          status,
   output logic                cur_bad,
   output logic                hold_restart
);
   localparam int SLOTS = 2 ** LEN_W;

   logic [1:0]       ent [SLOTS];
   logic [LEN_W-1:0] eff_len;
   logic [LEN_W-1:0] idx_q, idx_d;
   logic [LEN_W-1:0] fo_idx, fb_idx;
   logic             fo_found, fb_found;
   logic             latched_q, latched_d;
   logic             latch_active;
   logic             do_fo;

   for (genvar g = 0; g < SLOTS; g++) begin : g_ent
      if (g < LEVELS) begin : g_cfg
         assign ent[g] = cfg_prio[2*g +: 2];
      end else begin : g_pad
         assign ent[g] = SRC_NONE;
      end
   end

   always_comb begin
      if (cfg_manual || cfg_len == '0)
         eff_len = LEN_W'(1);
      else if (cfg_len > LEN_W'(LEVELS))
         eff_len = LEN_W'(LEVELS);
      else
         eff_len = cfg_len;
   end

   assign sel_src      = ent[idx_q];
   assign cur_bad      = src_bad[sel_src];
   assign latch_active = latched_q && cfg_latch && latch_rule;

   always_comb begin
      fo_found = 1'b0;
      fo_idx   = idx_q;
      fb_found = 1'b0;
      fb_idx   = idx_q;
      for (int j = SLOTS - 1; j >= 0; j--) begin
         if (LEN_W'(j) > idx_q && LEN_W'(j) < eff_len && !src_bad[ent[j]]) begin
            fo_found = 1'b1;
            fo_idx   = LEN_W'(j);
         end
         if (LEN_W'(j) < idx_q && src_settled[ent[j]]) begin
            fb_found = 1'b1;
            fb_idx   = LEN_W'(j);
         end
      end
   end

   always_comb begin
      do_fo = 1'b0;
      if (idx_q >= eff_len)
         idx_d = '0;
      else if (hold_expired && fo_found) begin
         idx_d = fo_idx;
         do_fo = 1'b1;
      end else if (fb_found && (!latch_active || sel_src == SRC_GEN))
         idx_d = fb_idx;
      else
         idx_d = idx_q;
   end

   always_comb begin
      if (do_fo && cfg_latch && latch_rule)
         latched_d = 1'b1;
      else if (latch_clr || idx_d == '0)
         latched_d = 1'b0;
      else
         latched_d = latched_q;
   end

   assign hold_restart = (idx_d != idx_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q     <= '0;
         latched_q <= 1'b0;
      end else begin
         idx_q     <= idx_d;
         latched_q <= latched_d;
      end
   end

   always_comb begin
      if (cur_bad)
         status = ST_HOLDING;
      else if (latch_active && idx_q != '0)
         status = ST_LATCHED;
      else if (idx_q == '0)
         status = ST_PRIMARY;
      else
         status = ST_BACKUP;
   end

   logic [3:0] prev_settled_q;
   always_ff @(posedge clk) prev_settled_q <= src_settled;

   // R2
   manual_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_manual |=> (idx_q == '0));

   // R4
   failover_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q > $past(idx_q)) |-> $past(hold_expired));

   // R5
   failback_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((idx_q < $past(idx_q)) && ($past(idx_q) < $past(eff_len)) && $stable(cfg_prio))
      |-> prev_settled_q[sel_src]);

   // R7
   latch_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_active && sel_src != SRC_GEN && idx_q < eff_len) |=> !(idx_q < $past(idx_q)));
endmodule

// File: rtl/prio_changeover.sv
module prio_changeover
   import cho_pkg::*;
#(
   parameter int TMR_W  = 16,
   parameter int LEVELS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ms_tick,
   input  logic                          cfg_manual,
   input  logic [$clog2(LEVELS+1)-1:0]   cfg_len,
   input  logic [2*LEVELS-1:0]           cfg_prio,
   input  logic [1:0]                    cfg_rule,
   input  logic                          cfg_latch,
   input  logic [TMR_W-1:0]              cfg_hold_ms,
   input  logic [TMR_W-1:0]              cfg_lock_ms,
   input  logic                          latch_clr,
   input  logic [1:0]                    in_los,
   input  logic [1:0]                    in_lol,
   input  logic [1:0]                    in_trs,
   output logic [1:0]                    sel_src,
   output logic [1:0]                    status
);
   localparam int LEN_W = $clog2(LEVELS + 1);

   if (LEVELS < 1 || LEVELS > 3) begin : g_lvl_bad
      $error("LEVELS must be 1..3");
   end
   if (TMR_W < 2) begin : g_tmr_bad
      $error("TMR_W too small");
   end

   logic [NPHYS-1:0] phys_bad, phys_settled;
   logic [3:0]       src_bad, src_settled;
   logic             cur_bad, hold_restart, hold_expired;

   for (genvar p = 0; p < NPHYS; p++) begin : g_phys
      cho_health #(.TMR_W(TMR_W)) u_health (
         .clk     (clk),
         .rst_n   (rst_n),
         .ms_tick (ms_tick),
         .rule    (cfg_rule),
         .los     (in_los[p]),
         .lol     (in_lol[p]),
         .trs     (in_trs[p]),
         .lock_ms (cfg_lock_ms),
         .bad     (phys_bad[p]),
         .settled (phys_settled[p])
      );
   end

   assign src_bad     = {1'b1, 1'b0, phys_bad};
   assign src_settled = {1'b0, 1'b1, phys_settled};

   cho_hold_timer #(.TMR_W(TMR_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .ms_tick (ms_tick),
      .cur_bad (cur_bad),
      .restart (hold_restart),
      .hold_ms (cfg_hold_ms),
      .expired (hold_expired)
   );

   cho_select #(.LEVELS(LEVELS), .LEN_W(LEN_W)) u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_manual   (cfg_manual),
      .cfg_len      (cfg_len),
      .cfg_prio     (cfg_prio),
      .cfg_latch    (cfg_latch),
      .latch_rule   (cfg_rule == RULE_LOS),
      .latch_clr    (latch_clr),
      .src_bad      (src_bad),
      .src_settled  (src_settled),
      .hold_expired (hold_expired),
      .sel_src      (sel_src),
      .status       (status),
      .cur_bad      (cur_bad),
      .hold_restart (hold_restart)
   );
endmodule

// File: tb/prio_changeover_bench.sv
module prio_changeover_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ms_tick;
   logic        cfg_manual;
   logic [1:0]  cfg_len;
   logic [5:0]  cfg_prio;
   logic [1:0]  cfg_rule;
   logic        cfg_latch;
   logic [15:0] cfg_hold_ms;
   logic [15:0] cfg_lock_ms;
   logic        latch_clr;
   logic [1:0]  in_los, in_lol, in_trs;
   logic [1:0]  sel_src, status;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   prio_changeover u_prio_changeover (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .cfg_manual(cfg_manual),
      .cfg_len(cfg_len), .cfg_prio(cfg_prio), .cfg_rule(cfg_rule),
      .cfg_latch(cfg_latch), .cfg_hold_ms(cfg_hold_ms), .cfg_lock_ms(cfg_lock_ms),
      .latch_clr(latch_clr), .in_los(in_los), .in_lol(in_lol), .in_trs(in_trs),
      .sel_src(sel_src), .status(status)
   );

   // row: los[17:16] lol[15:14] ticks[13:8] sel[7:6] status[5:4] req[3:0]
   localparam logic [17:0] VEC [10] = '{
      {2'b00, 2'b00, 6'd5,  2'd0, 2'd0, 4'd1},   // R1 idle on primary
      {2'b01, 2'b00, 6'd2,  2'd0, 2'd3, 4'd4},   // R4 one tick short of hold
      {2'b01, 2'b00, 6'd1,  2'd1, 2'd1, 4'd4},   // R4 hold reached
      {2'b00, 2'b00, 6'd3,  2'd1, 2'd1, 4'd5},   // R5 one short of lock
      {2'b00, 2'b00, 6'd1,  2'd0, 2'd0, 4'd5},   // R5 lock reached
      {2'b11, 2'b00, 6'd3,  2'd2, 2'd1, 4'd4},   // R4 both fail -> generator
      {2'b00, 2'b00, 6'd3,  2'd2, 2'd1, 4'd5},   // R5 both recovering
      {2'b00, 2'b00, 6'd1,  2'd0, 2'd0, 4'd11},  // R11 tie -> top entry
      {2'b10, 2'b00, 6'd10, 2'd0, 2'd0, 4'd12},  // R12 backup fault unseen
      {2'b00, 2'b01, 6'd5,  2'd0, 2'd0, 4'd3}    // R3 other flag ignored
   };

   task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp,
                      input string what);
      n_checks++;
      if (got !== exp) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic defaults();
      ms_tick = 1'b0; cfg_manual = 1'b0; cfg_len = 2'd3;
      cfg_prio = {2'd2, 2'd1, 2'd0}; cfg_rule = 2'd0; cfg_latch = 1'b0;
      cfg_hold_ms = 16'd3; cfg_lock_ms = 16'd4; latch_clr = 1'b0;
      in_los = 2'b00; in_lol = 2'b00; in_trs = 2'b00;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      defaults();
      @(negedge clk);
      do_reset();
      chk("R1", sel_src, 2'd0, "reset select");
      chk("R12", status, 2'd0, "reset status");

      // vector table walk
      for (int r = 0; r < 10; r++) begin
         in_los = VEC[r][17:16];
         in_lol = VEC[r][15:14];
         tick(int'(VEC[r][13:8]));
         chk($sformatf("R%0d row%0d", VEC[r][3:0], r), sel_src, VEC[r][7:6], "sel");
         chk($sformatf("R%0d row%0d", VEC[r][3:0], r), status, VEC[r][5:4], "status");
      end

      // R1 list order decides reset pick
      defaults(); cfg_prio = {2'd2, 2'd0, 2'd1};
      do_reset();
      chk("R1", sel_src, 2'd1, "reset with electrical first");

      // R2 manual mode never leaves entry 0
      defaults(); cfg_manual = 1'b1; do_reset();
      in_los = 2'b01; tick(10);
      chk("R2", sel_src, 2'd0, "manual stays");
      chk("R2", status, 2'd3, "manual holding status");

      // R3 loss-of-lock rule
      defaults(); cfg_rule = 2'd1; do_reset();
      in_los = 2'b01; tick(5);
      chk("R3", sel_src, 2'd0, "los ignored under lol rule");
      in_lol = 2'b01; tick(3);
      chk("R3", sel_src, 2'd1, "lol failover");

      // R3 timing-reference rule
      defaults(); cfg_rule = 2'd2; do_reset();
      in_los = 2'b01; in_lol = 2'b01; tick(10);
      chk("R3", sel_src, 2'd0, "los/lol ignored under trs rule");
      in_trs = 2'b01; tick(3);
      chk("R3", sel_src, 2'd1, "trs failover");

      // R6 glitch restarts hold then lock count
      defaults(); do_reset();
      in_los = 2'b01; tick(2);
      in_los = 2'b00; idle(1);
      in_los = 2'b01; tick(2);
      chk("R6", sel_src, 2'd0, "hold restarted");
      tick(1);
      chk("R6", sel_src, 2'd1, "hold after restart");
      in_los = 2'b00; tick(3);
      in_los = 2'b01; idle(1);
      in_los = 2'b00; tick(3);
      chk("R6", sel_src, 2'd1, "lock restarted");
      tick(1);
      chk("R6", sel_src, 2'd0, "lock after restart");

      // R7 latch blocks failback, R10 clear releases it
      defaults(); cfg_latch = 1'b1; do_reset();
      in_los = 2'b01; tick(3);
      chk("R7", sel_src, 2'd1, "latched failover");
      chk("R12", status, 2'd2, "latched status");
      in_los = 2'b00; tick(10);
      chk("R7", sel_src, 2'd1, "latched stays");
      latch_clr = 1'b1; idle(1); latch_clr = 1'b0; idle(2);
      chk("R10", sel_src, 2'd0, "clear lets failback");
      chk("R10", status, 2'd0, "clear status");

      // R8 latch ignored under loss-of-lock rule
      defaults(); cfg_latch = 1'b1; cfg_rule = 2'd1; do_reset();
      in_lol = 2'b01; tick(3);
      chk("R8", status, 2'd1, "not latched");
      in_lol = 2'b00; tick(4);
      chk("R8", sel_src, 2'd0, "failback despite latch");

      // R9 generator exited even when latched
      defaults(); cfg_latch = 1'b1; do_reset();
      in_los = 2'b11; tick(3);
      chk("R9", sel_src, 2'd2, "on generator");
      in_los = 2'b01; tick(4);
      chk("R9", sel_src, 2'd1, "leaves generator");
      in_los = 2'b00; tick(10);
      chk("R9", sel_src, 2'd1, "latched after leaving generator");
      chk("R12", status, 2'd2, "latched status on backup");

      // R13 short list: no usable lower entry
      defaults(); cfg_len = 2'd2; do_reset();
      in_los = 2'b11; tick(10);
      chk("R13", sel_src, 2'd0, "no healthy lower entry");
      chk("R13", status, 2'd3, "holding status");

      // R4 zero hold switches on next clock
      defaults(); cfg_hold_ms = 16'd0; do_reset();
      in_los = 2'b01; idle(2);
      chk("R4", sel_src, 2'd1, "zero hold");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule